// File: doc/BRIEF.md
# Stereo Programmable Sample Delay

This block delays a stream of stereo audio frames. Each frame arrives as a one-cycle strobe carrying one left and one right sample word. Every frame is written into a shared circular buffer, and each channel is read back from that buffer after its own programmed number of frame periods. The resulting pair leaves the block one clock cycle after the strobe that produced it. A channel can be forced to silence, and a pass-through mode sends the incoming pair straight to the outputs.

Configuration uses a byte-wide write port with an internal address pointer. After each byte the pointer advances, so one burst can program the whole bank. Each delay is 13 bits wide and is written as an upper byte and a lower byte. New delay bytes wait in shadow registers. They reach the datapath together only after a commit write, so the datapath never sees half of a delay value.

Top module: `stereo_sample_delay`

## Requirements
- R1: After reset, out_valid, out_left and out_right are 0. All configuration is zero: delay 0, no mute, normal mode, pointer 0. A frame then comes back unchanged.
- R2: out_valid is high for exactly the cycle after each cycle in which in_valid is high. In that cycle the outputs carry the result for that frame.
- R3: The register offsets are 0 control, 1 right delay upper, 2 right delay lower, 3 left delay upper, 4 left delay lower, 5 and 6 spare, 7 commit. The delay D of a channel is {upper[4:0], lower[7:0]}. In normal mode the channel outputs the sample it received D frames earlier.
- R4: The left and right delays are independent. Each channel follows only its own delay value.
- R5: A delay value above 4095 behaves exactly as a delay of 4095.
- R6: With a delay of 0, the channel outputs the sample of the same frame.
- R7: If fewer than D frames have arrived since reset, the channel outputs zero.
- R8: Control bit 6 mutes left and control bit 7 mutes right. A muted channel outputs zero in every mode.
- R9: A muted channel still records its input. After unmuting, the output shows the correctly delayed samples, including samples that arrived while the channel was muted.
- R10: Control bits 1:0 equal to 11 select bypass mode, in which each channel outputs its own frame input. The codes 00, 01 and 10 select delayed operation.
- R11: Writes to offsets 1 to 4 have no effect on the output until a write to offset 7. The new delays then take effect on the next frame strobe.
- R12: When cfg_addr_set is high, the pointer loads cfg_addr. A write goes to the loaded or current pointer, and afterwards the pointer holds that offset plus 1, wrapping from 7 to 0.
- R13: Writes to offsets 5 and 6 change nothing at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_set | input | 1 | Load the register pointer from cfg_addr |
| cfg_addr | input | 3 | Register offset to load |
| cfg_wr | input | 1 | Write cfg_wdata at the pointer, then advance the pointer |
| cfg_wdata | input | 8 | Register write byte |
| in_valid | input | 1 | Frame strobe |
| in_left | input | SAMPLE_W | Left input sample |
| in_right | input | SAMPLE_W | Right input sample |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | SAMPLE_W | Left output sample |
| out_right | output | SAMPLE_W | Right output sample |

## Verification
The assertions check the following on every cycle:
- the one-cycle link from frame strobe to out_valid;
- silence on a muted left channel;
- pass-through in bypass;
- zero output while the buffer is still filling;
- the active delays changing only on a committed strobe;
- the pointer advancing after each write.

Some properties need the bench's scenarios, because only a reference history of samples can show them:
- that each channel follows its own delay;
- that a muted channel resumes with the right history;
- that an over-range delay behaves as 4095 after more than 4096 frames;
- that a burst through the pointer lands on the intended registers.

// File: rtl/stereo_sample_delay.sv
module stereo_sample_delay #(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 12,
  parameter int DLY_W    = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_addr_set,
  input  logic [2:0]          cfg_addr,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_wdata,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MAX_DLY = DEPTH - 1;
  localparam int HI_W    = DLY_W - 8;

  logic [2:0]          ptr, wr_addr;
  logic                mute_l_q, mute_r_q, bypass_q, pend_q;
  logic [DLY_W-1:0]    sh_ld, sh_rd;
  logic [ADDR_W-1:0]   act_ld, act_rd, use_ld, use_rd;
  logic [ADDR_W-1:0]   wptr, fill;
  logic [2*SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] mem_l, mem_r, dly_l, dly_r, res_l, res_r;

  function automatic logic [ADDR_W-1:0] clamp(input logic [DLY_W-1:0] v);
    if (v > DLY_W'(MAX_DLY)) return ADDR_W'(MAX_DLY);
    return v[ADDR_W-1:0];
  endfunction

  assign wr_addr = cfg_addr_set ? cfg_addr : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      mute_l_q <= 1'b0;
      mute_r_q <= 1'b0;
      bypass_q <= 1'b0;
      sh_ld    <= '0;
      sh_rd    <= '0;
      act_ld   <= '0;
      act_rd   <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (cfg_wr)            ptr <= wr_addr + 3'd1;
      else if (cfg_addr_set) ptr <= cfg_addr;

      if (in_valid && pend_q) begin
        act_ld <= clamp(sh_ld);
        act_rd <= clamp(sh_rd);
        pend_q <= 1'b0;
      end

      if (cfg_wr) begin
        case (wr_addr)
          3'd0: begin
            mute_l_q <= cfg_wdata[6];
            mute_r_q <= cfg_wdata[7];
            bypass_q <= &cfg_wdata[1:0];
          end
          3'd1: sh_rd[DLY_W-1:8] <= cfg_wdata[HI_W-1:0];
          3'd2: sh_rd[7:0]       <= cfg_wdata;
          3'd3: sh_ld[DLY_W-1:8] <= cfg_wdata[HI_W-1:0];
          3'd4: sh_ld[7:0]       <= cfg_wdata;
          3'd7: pend_q           <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign use_ld = pend_q ? clamp(sh_ld) : act_ld;
  assign use_rd = pend_q ? clamp(sh_rd) : act_rd;

  assign mem_l = mem[wptr - use_ld][SAMPLE_W-1:0];
  assign mem_r = mem[wptr - use_rd][2*SAMPLE_W-1:SAMPLE_W];

  assign dly_l = (use_ld == '0) ? in_left  : ((use_ld <= fill) ? mem_l : '0);
  assign dly_r = (use_rd == '0) ? in_right : ((use_rd <= fill) ? mem_r : '0);

  assign res_l = mute_l_q ? '0 : (bypass_q ? in_left  : dly_l);
  assign res_r = mute_r_q ? '0 : (bypass_q ? in_right : dly_r);

  always_ff @(posedge clk) begin
    if (in_valid) mem[wptr] <= {in_right, in_left};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wptr      <= wptr + 1'b1;
        fill      <= (fill == ADDR_W'(MAX_DLY)) ? fill : fill + 1'b1;
        out_left  <= res_l;
        out_right <= res_r;
      end
    end
  end
endmodule

module stereo_sample_delay_chk #(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_left,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_left,
  input logic                mute_l_q,
  input logic                bypass_q,
  input logic                pend_q,
  input logic [ADDR_W-1:0]   act_ld,
  input logic [ADDR_W-1:0]   act_rd,
  input logic [ADDR_W-1:0]   use_ld,
  input logic [ADDR_W-1:0]   fill,
  input logic                cfg_wr,
  input logic                cfg_addr_set,
  input logic [2:0]          ptr
);
  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  mute_left_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mute_l_q |=> out_left == '0);
  // R10
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && bypass_q && !mute_l_q |=> out_left == $past(in_left));
  // R7
  prefill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !bypass_q && !mute_l_q && (use_ld > fill) |=> out_left == '0);
  // R11
  delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && pend_q) |=> $stable(act_ld) && $stable(act_rd));
  // R12
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_addr_set |=> ptr == $past(ptr) + 3'd1);
endmodule

bind stereo_sample_delay stereo_sample_delay_chk #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
  .out_valid(out_valid), .out_left(out_left), .mute_l_q(mute_l_q),
  .bypass_q(bypass_q), .pend_q(pend_q), .act_ld(act_ld), .act_rd(act_rd),
  .use_ld(use_ld), .fill(fill), .cfg_wr(cfg_wr), .cfg_addr_set(cfg_addr_set),
  .ptr(ptr)
);

// File: tb/stereo_sample_delay_tb_top.sv
`timescale 1ns/1ps
module stereo_sample_delay_tb_top;
  localparam int SW = 24;
  localparam int MAXD = 4095;
  localparam int HMAX = 10000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, cfg_addr_set = 1'b0, cfg_wr = 1'b0, in_valid = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [SW-1:0] in_left = '0, in_right = '0;
  logic out_valid;
  logic [SW-1:0] out_left, out_right;

  stereo_sample_delay dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr_set(cfg_addr_set), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  int checks = 0, errors = 0;
  logic [SW-1:0] hist_l [HMAX];
  logic [SW-1:0] hist_r [HMAX];
  int nfr = 0;
  bit m_ml, m_mr, m_byp, m_pend;
  int m_sh_l, m_sh_r, m_act_l, m_act_r, m_ptr;
  string cur_req = "R1";

  typedef struct { logic [SW-1:0] l; logic [SW-1:0] r; string req; } exp_t;
  exp_t q[$];

  function automatic int clampd(int v);
    return (v > MAXD) ? MAXD : v;
  endfunction

  function automatic logic [SW-1:0] pick(bit left, int d, logic [SW-1:0] cur);
    if (d == 0) return cur;
    if (d > nfr) return '0;
    return left ? hist_l[nfr-d] : hist_r[nfr-d];
  endfunction

  task automatic reg_wr(bit set, int a, logic [7:0] d);
    int addr;
    @(negedge clk);
    cfg_addr_set = set; cfg_addr = 3'(a); cfg_wr = 1'b1; cfg_wdata = d;
    addr = set ? a : m_ptr;
    case (addr)
      0: begin m_ml = d[6]; m_mr = d[7]; m_byp = (d[1:0] == 2'b11); end
      1: m_sh_r = (m_sh_r & 'hFF)   | (int'(d[4:0]) << 8);
      2: m_sh_r = (m_sh_r & 'h1F00) | int'(d);
      3: m_sh_l = (m_sh_l & 'hFF)   | (int'(d[4:0]) << 8);
      4: m_sh_l = (m_sh_l & 'h1F00) | int'(d);
      7: m_pend = 1'b1;
      default: ;
    endcase
    m_ptr = (addr + 1) % 8;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr_set = 1'b0;
  endtask

  task automatic frame(logic [SW-1:0] l, logic [SW-1:0] r);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    if (m_pend) begin
      m_act_l = clampd(m_sh_l); m_act_r = clampd(m_sh_r); m_pend = 1'b0;
    end
    e.l = m_ml ? '0 : (m_byp ? l : pick(1'b1, m_act_l, l));
    e.r = m_mr ? '0 : (m_byp ? r : pick(1'b0, m_act_r, r));
    e.req = cur_req;
    q.push_back(e);
    hist_l[nfr] = l; hist_r[nfr] = r; nfr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) frame(SW'($urandom), SW'($urandom));
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2: out_valid act 1 exp 0 (no frame pending)");
      end else begin
        e = q.pop_front();
        if (out_left !== e.l || out_right !== e.r) begin
          errors++;
          $display("FAIL %s: out L/R act %h/%h exp %h/%h", e.req, out_left, out_right, e.l, e.r);
        end
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_left !== '0 || out_right !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs act %b/%h/%h exp 0/0/0", out_valid, out_left, out_right);
    end
    cur_req = "R1"; frames(3);

    reg_wr(1'b1, 0, 8'h00);
    reg_wr(1'b0, 0, 8'h00);
    reg_wr(1'b0, 0, 8'h05);
    reg_wr(1'b0, 0, 8'h00);
    reg_wr(1'b0, 0, 8'h02);
    reg_wr(1'b0, 0, 8'hAA);
    reg_wr(1'b0, 0, 8'h55);
    reg_wr(1'b0, 0, 8'h01);
    cur_req = "R7"; frames(3);
    cur_req = "R4"; frames(10);
    cur_req = "R13"; frames(4);

    reg_wr(1'b1, 1, 8'h00);
    reg_wr(1'b0, 0, 8'h09);
    cur_req = "R11"; frames(5);
    reg_wr(1'b1, 7, 8'h00);
    cur_req = "R3"; frames(12);

    reg_wr(1'b0, 0, 8'h40);
    cur_req = "R12"; frames(3);
    reg_wr(1'b1, 0, 8'h80);
    cur_req = "R8"; frames(3);
    reg_wr(1'b1, 0, 8'hC0);
    frames(3);
    reg_wr(1'b1, 0, 8'h40);
    cur_req = "R9"; frames(6);
    reg_wr(1'b1, 0, 8'h00);
    frames(6);

    reg_wr(1'b1, 0, 8'h03);
    cur_req = "R10"; frames(5);
    reg_wr(1'b1, 0, 8'h01);
    frames(3);
    reg_wr(1'b1, 0, 8'h02);
    frames(3);
    reg_wr(1'b1, 0, 8'h43);
    frames(3);
    reg_wr(1'b1, 0, 8'h00);

    reg_wr(1'b1, 3, 8'h00);
    reg_wr(1'b0, 0, 8'h00);
    reg_wr(1'b0, 0, 8'h11);
    reg_wr(1'b0, 0, 8'h22);
    reg_wr(1'b0, 0, 8'h00);
    cur_req = "R6"; frames(5);

    reg_wr(1'b1, 1, 8'h0F);
    reg_wr(1'b0, 0, 8'hFF);
    reg_wr(1'b0, 0, 8'h10);
    reg_wr(1'b0, 0, 8'h00);
    reg_wr(1'b1, 7, 8'h00);
    cur_req = "R5"; frames(4200);

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: frames without output act %0d exp 0", q.size());
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run act hung exp done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule